// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Controller

This block moves a DRAM into its low-power self-refresh state when the host asks it to sleep. It brings the DRAM back out when the host asks it to wake. It borrows the row and column strobes from the refresh scheduler through that scheduler's request/grant handshake, and it returns them when the whole sequence is over.

Before entry it runs one column-before-row refresh cycle. Entry itself uses the same edge order: the column strobe falls first, then the row strobe. The row strobe then stays low for at least the minimum self-refresh hold time, so it is never released inside the window where the device is only part-way into the mode. On exit the column strobe may rise a set number of cycles ahead of the row strobe. A long recovery precharge and a second refresh cycle follow, and then a one-cycle wake-complete pulse.

The block also counts the distributed refresh cycles that the scheduler reports. A new entry waits until every row has been refreshed again since the last exit. A sleep request that rises too early raises an error pulse and waits.

All times are parameters in clock cycles:

| Parameter | Meaning |
|---|---|
| `T_CSR` | column strobe lead before the row strobe falls |
| `T_RASW` | row strobe low time in a refresh cycle |
| `T_RP` | normal precharge |
| `T_HOLD` | minimum self-refresh hold |
| `CAS_LEAD` | early column strobe rise on exit |
| `T_XRP` | exit precharge |
| `ROWS` | number of rows to refresh |

Top module: `dram_selfrefresh_mgr`

## Requirements
- R1: In reset and right after it, `ras_n` and `cas_n` are high, and `strobe_req`, `sleeping`, `wake_done` and `reentry_err` are low.
- R2: When `sleep_req` is high in idle and the refresh guard is satisfied, `strobe_req` rises in the next cycle. Both strobes stay high until `strobe_grant` is seen.
- R3: The edge that samples `strobe_grant` high starts a refresh cycle before entry. `cas_n` alone is low for `T_CSR` cycles, then both strobes are low for `T_RASW` cycles, then both are high for `T_RP` cycles.
- R4: Entry follows the refresh cycle. `cas_n` is low alone for `T_CSR` cycles, then `ras_n` falls as well. `sleeping` is high exactly while the device is held in self-refresh.
- R5: `ras_n` stays low in self-refresh for at least `T_HOLD` cycles. A `wake_req` that comes earlier is held until the hold time has elapsed.
- R6: On wake, `cas_n` rises `CAS_LEAD` cycles before `ras_n`. Both strobes then stay high for `T_XRP` cycles.
- R7: The recovery precharge is followed by a refresh cycle with the R3 timing. `wake_done` is high for one cycle, in the last precharge cycle of that refresh. `strobe_req` falls in the cycle after.
- R8: `wake_done` clears the count of refresh cycles. Each `cbr_done` pulse adds one to the count, which saturates at `ROWS`. A rising edge of `sleep_req` in idle while the count is below `ROWS` gives a one-cycle `reentry_err` in the next cycle, and no entry starts.
- R9: A `sleep_req` held high through the guard starts the entry, per R2, as soon as the count reaches `ROWS`.
- R10: After reset the guard counts as satisfied, so the first entry needs no `cbr_done` pulse.
- R11: Whenever `strobe_req` is low, both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Host level request to enter self-refresh |
| wake_req | input | 1 | Host level request to leave self-refresh |
| cbr_done | input | 1 | One-cycle pulse per distributed refresh cycle completed by the scheduler |
| strobe_grant | input | 1 | Scheduler grants the strobe lines to this block |
| strobe_req | output | 1 | Request for the strobe lines, held for the whole sequence |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| sleeping | output | 1 | Device is held in self-refresh |
| wake_done | output | 1 | One-cycle pulse when the exit sequence completes |
| reentry_err | output | 1 | One-cycle pulse for a sleep request refused by the refresh guard |

## Verification
The strobes, `sleeping`, `strobe_req` and `wake_done` are decoded from the state register. Each of them therefore changes in the cycle that follows the clock edge that sampled its cause. `reentry_err` goes through one more flop, so it is due one cycle after the edge that sees `sleep_req` rise. The bench's behavioural model advances on every rising edge from the same input values and holds its own per-cycle strobe script. The model's predictions are compared with the ports on the falling edge, so every expected value lines up with the cycle in which it is due.

// File: rtl/srm_pkg.sv
package srm_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ACQ,
      ST_PRE_CAS,
      ST_PRE_RAS,
      ST_PRE_RP,
      ST_ENT_CAS,
      ST_SLEEP,
      ST_EXIT_CAS,
      ST_EXIT_RP,
      ST_POST_CAS,
      ST_POST_RAS,
      ST_POST_RP
   } srm_state_t;

   function automatic int srm_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/srm_timer.sv
module srm_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          zero
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/srm_refcnt.sv
module srm_refcnt #(
   parameter int ROWS = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clear,
   output logic full
);

   localparam int CW = $clog2(ROWS + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= CW'(ROWS);
      else if (clear)
         cnt_q <= '0;
      else if (tick && cnt_q != CW'(ROWS))
         cnt_q <= cnt_q + 1'b1;
   end

   assign full = (cnt_q == CW'(ROWS));

   assert_count_bound_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(ROWS));

   assert_clear_on_wake_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0));

endmodule

// File: rtl/srm_seq.sv
module srm_seq
   import srm_pkg::*;
#(
   parameter int T_CSR    = 1,
   parameter int T_RASW   = 12,
   parameter int T_RP     = 8,
   parameter int T_HOLD   = 20000,
   parameter int CAS_LEAD = 1,
   parameter int T_XRP    = 22
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       grant,
   input  logic       wake_req,
   output srm_state_t state
);

   localparam int TMAX = srm_max(srm_max(srm_max(T_CSR, T_RASW), srm_max(T_RP, T_HOLD)),
                                 srm_max(CAS_LEAD, T_XRP));
   localparam int TW   = $clog2(TMAX + 1);
   localparam int HW   = $clog2(T_HOLD + 1);

   srm_state_t    state_q, nxt;
   logic          ld, tmr_zero;
   logic [TW-1:0] ld_val;
   srm_state_t    exit_st;
   logic [TW-1:0] exit_val;

   generate
      if (T_CSR < 1 || T_RASW < 1 || T_RP < 1 || T_XRP < 1) begin : g_bad_time
         $error("srm_seq: every phase must last at least one cycle");
      end
      if (T_HOLD < 2) begin : g_bad_hold
         $error("srm_seq: T_HOLD must be at least two cycles");
      end
      if (CAS_LEAD > 0) begin : g_lead
         assign exit_st  = ST_EXIT_CAS;
         assign exit_val = TW'(CAS_LEAD - 1);
      end else begin : g_nolead
         assign exit_st  = ST_EXIT_RP;
         assign exit_val = TW'(T_XRP - 1);
      end
   endgenerate

   srm_timer #(.TW(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .zero     (tmr_zero)
   );

   always_comb begin
      nxt    = state_q;
      ld     = 1'b0;
      ld_val = '0;
      unique case (state_q)
         ST_IDLE: if (go) nxt = ST_ACQ;
         ST_ACQ: if (grant) begin
            nxt = ST_PRE_CAS;  ld = 1'b1; ld_val = TW'(T_CSR - 1);
         end
         ST_PRE_CAS: if (tmr_zero) begin
            nxt = ST_PRE_RAS;  ld = 1'b1; ld_val = TW'(T_RASW - 1);
         end
         ST_PRE_RAS: if (tmr_zero) begin
            nxt = ST_PRE_RP;   ld = 1'b1; ld_val = TW'(T_RP - 1);
         end
         ST_PRE_RP: if (tmr_zero) begin
            nxt = ST_ENT_CAS;  ld = 1'b1; ld_val = TW'(T_CSR - 1);
         end
         ST_ENT_CAS: if (tmr_zero) begin
            nxt = ST_SLEEP;    ld = 1'b1; ld_val = TW'(T_HOLD - 1);
         end
         ST_SLEEP: if (tmr_zero && wake_req) begin
            nxt = exit_st;     ld = 1'b1; ld_val = exit_val;
         end
         ST_EXIT_CAS: if (tmr_zero) begin
            nxt = ST_EXIT_RP;  ld = 1'b1; ld_val = TW'(T_XRP - 1);
         end
         ST_EXIT_RP: if (tmr_zero) begin
            nxt = ST_POST_CAS; ld = 1'b1; ld_val = TW'(T_CSR - 1);
         end
         ST_POST_CAS: if (tmr_zero) begin
            nxt = ST_POST_RAS; ld = 1'b1; ld_val = TW'(T_RASW - 1);
         end
         ST_POST_RAS: if (tmr_zero) begin
            nxt = ST_POST_RP;  ld = 1'b1; ld_val = TW'(T_RP - 1);
         end
         ST_POST_RP: if (tmr_zero) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= nxt;
   end

   assign state = state_q;

   // Checker: cycles spent in self-refresh, counted apart from the timer.
   logic [HW-1:0] slp_cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         slp_cyc <= '0;
      else if (state_q != ST_SLEEP)
         slp_cyc <= '0;
      else if (slp_cyc != HW'(T_HOLD))
         slp_cyc <= slp_cyc + 1'b1;
   end

   assert_hold_min_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP && nxt != ST_SLEEP) |-> (slp_cyc >= HW'(T_HOLD - 1)));

   assert_wake_needs_req_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP && nxt != ST_SLEEP) |-> wake_req);

endmodule

// File: rtl/dram_selfrefresh_mgr.sv
module dram_selfrefresh_mgr
   import srm_pkg::*;
#(
   parameter int T_CSR    = 1,
   parameter int T_RASW   = 12,
   parameter int T_RP     = 8,
   parameter int T_HOLD   = 20000,
   parameter int CAS_LEAD = 1,
   parameter int T_XRP    = 22,
   parameter int ROWS     = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic wake_req,
   input  logic cbr_done,
   input  logic strobe_grant,
   output logic strobe_req,
   output logic ras_n,
   output logic cas_n,
   output logic sleeping,
   output logic wake_done,
   output logic reentry_err
);

   srm_state_t st;
   logic       guard_full;
   logic       sreq_q, err_q;

   srm_seq #(
      .T_CSR    (T_CSR),
      .T_RASW   (T_RASW),
      .T_RP     (T_RP),
      .T_HOLD   (T_HOLD),
      .CAS_LEAD (CAS_LEAD),
      .T_XRP    (T_XRP)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (sleep_req && guard_full),
      .grant    (strobe_grant),
      .wake_req (wake_req),
      .state    (st)
   );

   srm_refcnt #(.ROWS(ROWS)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (cbr_done),
      .clear (wake_done),
      .full  (guard_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreq_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         sreq_q <= sleep_req;
         err_q  <= (st == ST_IDLE) && sleep_req && !sreq_q && !guard_full;
      end
   end

   always_comb begin
      cas_n = !(st inside {ST_PRE_CAS, ST_PRE_RAS, ST_ENT_CAS, ST_SLEEP,
                           ST_POST_CAS, ST_POST_RAS});
      ras_n = !(st inside {ST_PRE_RAS, ST_SLEEP, ST_EXIT_CAS, ST_POST_RAS});
   end

   assign strobe_req  = (st != ST_IDLE);
   assign sleeping    = (st == ST_SLEEP);
   assign wake_done   = (st == ST_POST_RP) && (u_seq.nxt == ST_IDLE);
   assign reentry_err = err_q;

   assert_cbr_order_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

   assert_owned_strobes_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n || !cas_n) |-> strobe_grant);

   assert_guard_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_req) |-> $past(guard_full));

   assert_err_idle_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      reentry_err |-> !strobe_req);

   assert_wake_pulse_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      wake_done |=> !wake_done && !strobe_req);

endmodule

// File: tb/tb_dram_selfrefresh_mgr.sv
`timescale 1ns/1ps
module tb_dram_selfrefresh_mgr;

   localparam int T_CSR = 2, T_RASW = 4, T_RP = 3, T_HOLD = 40;
   localparam int CAS_LEAD = 2, T_XRP = 5, ROWS = 8;

   logic clk = 0, rst_n = 0;
   logic sleep_req = 0, wake_req = 0, cbr_done = 0, strobe_grant = 0;
   logic strobe_req, ras_n, cas_n, sleeping, wake_done, reentry_err;

   dram_selfrefresh_mgr #(
      .T_CSR(T_CSR), .T_RASW(T_RASW), .T_RP(T_RP), .T_HOLD(T_HOLD),
      .CAS_LEAD(CAS_LEAD), .T_XRP(T_XRP), .ROWS(ROWS)
   ) dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .cbr_done(cbr_done), .strobe_grant(strobe_grant), .strobe_req(strobe_req),
      .ras_n(ras_n), .cas_n(cas_n), .sleeping(sleeping), .wake_done(wake_done),
      .reentry_err(reentry_err)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0, grant_dly = 0, gcnt = 0;
   int n_err_seen = 0, n_wake_seen = 0;

   // ---------------- behavioural reference model ----------------
   logic [3:0] q[$];            // {ras_n, cas_n, sleeping, wake_done} per cycle
   string      cq[$];
   logic [3:0] e = 4'b1100;
   logic       ebreq = 0, eerr = 0, prev = 0, exitscr = 0, clr;
   string      tag = "R1";
   int         mode = 0, cnt = ROWS, slpc = 0;

   task automatic push(input int n, input logic [3:0] v, input string t);
      for (int i = 0; i < n; i++) begin q.push_back(v); cq.push_back(t); end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); cq.delete();
         mode = 0; e = 4'b1100; ebreq = 0; eerr = 0; prev = 0;
         cnt = ROWS; exitscr = 0; tag = "R1";
      end else begin
         clr  = 0;
         eerr = (mode == 0) && sleep_req && !prev && (cnt < ROWS);
         prev = sleep_req;
         case (mode)
            0: if (sleep_req && cnt == ROWS) begin mode = 1; ebreq = 1; tag = "R2"; end
            1: if (strobe_grant) begin
                  push(T_CSR, 4'b1000, "R3"); push(T_RASW, 4'b0000, "R3");
                  push(T_RP, 4'b1100, "R3");  push(T_CSR, 4'b1000, "R4");
                  e = q.pop_front(); tag = cq.pop_front(); mode = 2;
               end
            2: if (q.size() > 0) begin e = q.pop_front(); tag = cq.pop_front(); end
               else if (!exitscr) begin mode = 3; e = 4'b0010; slpc = 1; tag = "R5"; end
               else begin mode = 0; e = 4'b1100; ebreq = 0; clr = 1; exitscr = 0; tag = "R7"; end
            3: if (slpc >= T_HOLD && wake_req) begin
                  push(CAS_LEAD, 4'b0100, "R6"); push(T_XRP, 4'b1100, "R6");
                  push(T_CSR, 4'b1000, "R7");    push(T_RASW, 4'b0000, "R7");
                  push(T_RP - 1, 4'b1100, "R7"); push(1, 4'b1101, "R7");
                  exitscr = 1; e = q.pop_front(); tag = cq.pop_front(); mode = 2;
               end else slpc++;
            default: mode = 0;
         endcase
         if (clr) cnt = 0;
         else if (cbr_done && cnt < ROWS) cnt++;
      end
   end

   // ---------------- per-cycle comparison ----------------
   task automatic chk(input string what, input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         chk("ras_n", tag, ras_n, e[3]);
         chk("cas_n", tag, cas_n, e[2]);
         chk("sleeping", tag, sleeping, e[1]);
         chk("wake_done", "R7", wake_done, e[0]);
         chk("strobe_req", "R2", strobe_req, ebreq);
         chk("reentry_err", "R8", reentry_err, eerr);
         if (!strobe_req) chk("strobes idle R11", "R11", ras_n & cas_n, 1'b1);
         if (reentry_err) n_err_seen++;
         if (wake_done) n_wake_seen++;
      end
   end

   // grant driver: scheduler answers after grant_dly cycles
   always @(negedge clk) begin
      if (!strobe_req) begin strobe_grant = 0; gcnt = 0; end
      else if (gcnt >= grant_dly) strobe_grant = 1;
      else gcnt++;
   end

   task automatic wait_for_sleep();
      int k = 0;
      while (!sleeping && k < 500) begin @(negedge clk); k++; end
   endtask

   task automatic wait_for_wake();
      int k = 0;
      while (!wake_done && k < 500) begin @(negedge clk); k++; end
   endtask

   task automatic pulse_cbr(input int n);
      for (int i = 0; i < n; i++) begin
         cbr_done = 1; @(negedge clk); cbr_done = 0; @(negedge clk);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("ras_n in reset", "R1", ras_n, 1'b1);
      chk("cas_n in reset", "R1", cas_n, 1'b1);
      chk("strobe_req in reset", "R1", strobe_req, 1'b0);
      chk("sleeping/wake/err in reset", "R1", sleeping | wake_done | reentry_err, 1'b0);
      rst_n = 1;
      repeat (3) @(negedge clk);

      // R10: first entry with no refresh pulses; grant late (R2); early wake (R5)
      grant_dly = 3;
      sleep_req = 1;
      @(negedge clk);
      chk("strobe_req after first sleep_req R10", "R10", strobe_req, 1'b1);
      wait_for_sleep();
      sleep_req = 0;
      wake_req = 1;
      wait_for_wake();
      @(negedge clk);
      wake_req = 0;
      chk("one wake pulse R7", "R7", n_wake_seen == 1, 1'b1);

      // R8: refused re-entry before the array is refreshed again
      repeat (2) @(negedge clk);
      grant_dly = 0;
      sleep_req = 1;
      repeat (3) @(negedge clk);
      chk("no entry while guard open R8", "R8", strobe_req, 1'b0);
      sleep_req = 0;
      repeat (2) @(negedge clk);
      pulse_cbr(5);
      sleep_req = 1;
      repeat (3) @(negedge clk);
      chk("two refusals R8", "R8", n_err_seen == 2, 1'b1);
      chk("still idle after 5 refreshes R8", "R8", strobe_req, 1'b0);

      // R9: held request proceeds once the count is full
      pulse_cbr(ROWS - 5);
      chk("entry after full count R9", "R9", strobe_req, 1'b1);
      wait_for_sleep();
      sleep_req = 0;
      repeat (T_HOLD + 10) @(negedge clk);
      chk("still asleep without wake R5", "R5", sleeping, 1'b1);
      wake_req = 1;
      wait_for_wake();
      @(negedge clk);
      wake_req = 0;
      repeat (5) @(negedge clk);
      chk("two wake pulses R7", "R7", n_wake_seen == 2, 1'b1);
      chk("no extra errors R8", "R8", n_err_seen == 2, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule